// File: doc/BRIEF.md
# Weight-Stationary Systolic Multiply-Accumulate Array

This block is a square grid of N×N multiply-accumulate elements. Each element keeps one signed 16-bit weight. Weights are loaded one grid row per cycle while the array is idle. After loading, a caller streams K activation vectors into the west edge. Each row carries one component of the vector. Row i is delayed by i cycles with respect to row 0, so the vector enters as a diagonal wavefront.

Activations travel east from element to element. Partial sums travel south. Each column therefore produces one 40-bit dot product per vector at its south edge, and the outputs are skewed by column in the same way as the inputs. Every element also reports, in every cycle, whether it performs a multiply-accumulate in that cycle. This lets a utilization monitor count the real wavefront occupancy and compare it with the peak rate.

The weights are fixed during a run. A weight-load request that arrives while any activation or partial sum is still moving through the grid is discarded, and a sticky error flag is raised.

Top module: `systolic_mac_array`

## Requirements
- R1: A synchronous active-high reset clears all weights, moving activations, partial sums and valid flags, and clears the error flag. While reset is held, `ps_valid`, `pe_active` and `load_err` are all 0. After reset, a stream produces all-zero sums until new weights are loaded.
- R2: When `wl_en` is high and the grid is idle, the clock edge stores `wl_data[j*16 +: 16]` as the signed weight of element (`wl_row`, j), for every column j.
- R3: Let cycle 0 be the cycle in which row 0 receives its first vector, and let row i receive vector k in cycle k+i. Then `pe_active[i*N+j]` is 1 exactly in cycles i+j through i+j+K-1.
- R4: Column j presents the result for vector k on `ps_data[j*40 +: 40]` in cycle k+j+N. The result is the sum over i of weight(i,j) × activation k of row i, using signed 16×16 products in 40-bit two's complement.
- R5: Over a run of K vectors, the `pe_active` bits summed over all cycles total exactly N·N·K.
- R6: A `wl_en` that arrives while any `act_valid` bit or any valid register inside the grid is set changes no weight. From the next cycle, `load_err` reads 1, and it stays 1 until reset.
- R7: Full-scale signed operands (−32768 and 32767) accumulate over all N rows without wraparound.
- R8: `ps_valid[j]` is 1 only in the cycles named in R4 and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wl_en | input | 1 | Weight-row write request |
| wl_row | input | $clog2(N) | Grid row to write |
| wl_data | input | N*16 | Weights for that row, column j at bits j*16 |
| act_valid | input | N | Per-row activation valid |
| act_data | input | N*16 | Per-row signed activation, row i at bits i*16 |
| ps_valid | output | N | Per-column result valid |
| ps_data | output | N*40 | Per-column signed result, column j at bits j*40 |
| pe_active | output | N*N | Element (i,j) multiplies this cycle, bit i*N+j |
| load_err | output | 1 | Sticky flag for a weight load during a run |

## Verification
Two functions can fall in the same cycle: a weight-row write request and an activation wavefront that is still crossing the grid. The bench raises `wl_en` two cycles into a stream, with a row of weights that differs from the resident ones. It then judges the outcome in two ways. `load_err` must read 1 in the following cycle and afterwards. Every column result of that stream must still match the sums computed from the old weights. A later load while the grid is idle must take effect, and a reset must clear both the flag and the weights.

// File: rtl/systolic_mac_array.sv
module systolic_mac_array #(
  parameter int N  = 8,
  parameter int DW = 16,
  parameter int AW = 40,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wl_en,
  input  logic [IW-1:0]     wl_row,
  input  logic [N*DW-1:0]   wl_data,
  input  logic [N-1:0]      act_valid,
  input  logic [N*DW-1:0]   act_data,
  output logic [N-1:0]      ps_valid,
  output logic [N*AW-1:0]   ps_data,
  output logic [N*N-1:0]    pe_active,
  output logic              load_err
);

  logic [N*N-1:0] av_f, sv_f;
  logic           busy;

  assign busy = (|act_valid) | (|av_f) | (|sv_f);

  for (genvar i = 0; i < N; i++) begin : g_r
    for (genvar j = 0; j < N; j++) begin : g_c
      logic signed [DW-1:0]   w_q, a_q, a_in;
      logic signed [AW-1:0]   s_q, s_in;
      logic signed [2*DW-1:0] prod;
      logic                   av_q, sv_q, v_in;

      if (j == 0) begin : g_west
        assign a_in = act_data[i*DW +: DW];
        assign v_in = act_valid[i];
      end else begin : g_inner
        assign a_in = g_r[i].g_c[j-1].a_q;
        assign v_in = g_r[i].g_c[j-1].av_q;
      end

      if (i == 0) begin : g_north
        assign s_in = '0;
      end else begin : g_below
        assign s_in = g_r[i-1].g_c[j].s_q;
      end

      assign prod = w_q * a_in;

      always_ff @(posedge clk) begin
        if (rst) begin
          w_q  <= '0;
          a_q  <= '0;
          s_q  <= '0;
          av_q <= 1'b0;
          sv_q <= 1'b0;
        end else begin
          av_q <= v_in;
          sv_q <= v_in;
          if (v_in) begin
            a_q <= a_in;
            s_q <= s_in + AW'(prod);
          end
          if (wl_en && !busy && wl_row == IW'(i))
            w_q <= wl_data[j*DW +: DW];
        end
      end

      assign pe_active[i*N+j] = v_in;
      assign av_f[i*N+j]      = av_q;
      assign sv_f[i*N+j]      = sv_q;
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_out
    assign ps_valid[j]          = g_r[N-1].g_c[j].sv_q;
    assign ps_data[j*AW +: AW]  = g_r[N-1].g_c[j].s_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                load_err <= 1'b0;
    else if (wl_en && busy) load_err <= 1'b1;
  end

endmodule

module systolic_mac_array_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           wl_en,
  input logic [N-1:0]   ps_valid,
  input logic [N*N-1:0] pe_active,
  input logic           load_err
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (ps_valid == '0 && !load_err));

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    load_err |=> load_err);

  a_r6_err_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(load_err) |-> $past(wl_en));

  for (genvar j = 0; j < N; j++) begin : g_col
    a_r8_valid_follows_active: assert property (@(posedge clk) disable iff (rst)
      ps_valid[j] |-> $past(pe_active[(N-1)*N+j]));
  end

endmodule

bind systolic_mac_array systolic_mac_array_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .wl_en(wl_en), .ps_valid(ps_valid),
  .pe_active(pe_active), .load_err(load_err)
);

// File: tb/test_systolic_mac_array.sv
module test_systolic_mac_array;
  localparam int N = 8, DW = 16, AW = 40, KMAX = 80, IW = $clog2(N);

  logic            clk = 1'b0, rst = 1'b1, wl_en = 1'b0;
  logic [IW-1:0]   wl_row = '0;
  logic [N*DW-1:0] wl_data = '0, act_data = '0;
  logic [N-1:0]    act_valid = '0;
  logic [N-1:0]    ps_valid;
  logic [N*AW-1:0] ps_data;
  logic [N*N-1:0]  pe_active;
  logic            load_err;

  int checks = 0, errors = 0;
  bit done = 0;
  int w_m [N][N];
  int acts [KMAX][N];

  always #10 clk = ~clk;

  systolic_mac_array #(.N(N), .DW(DW), .AW(AW)) i_systolic_mac_array (
    .clk(clk), .rst(rst), .wl_en(wl_en), .wl_row(wl_row), .wl_data(wl_data),
    .act_valid(act_valid), .act_data(act_data), .ps_valid(ps_valid),
    .ps_data(ps_data), .pe_active(pe_active), .load_err(load_err));

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd16();
    logic [15:0] r;
    r = 16'($urandom);
    return int'($signed(r));
  endfunction

  function automatic longint exp_sum(int k, int j);
    longint s = 0;
    for (int i = 0; i < N; i++) s += longint'(w_m[i][j]) * longint'(acts[k][i]);
    return s;
  endfunction

  task automatic load_weights();
    for (int r = 0; r < N; r++) begin
      @(negedge clk);
      wl_en  = 1'b1;
      wl_row = IW'(r);
      for (int j = 0; j < N; j++) wl_data[j*DW +: DW] = DW'(w_m[r][j]);
    end
    @(negedge clk);
    wl_en = 1'b0;
  endtask

  task automatic run_stream(int K, bit inject, string tag);
    int act_cnt = 0, abad = 0, vbad = 0;
    for (int t = 0; t < K + 2*N + 2; t++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        int k = t - i;
        act_valid[i] = (k >= 0 && k < K);
        act_data[i*DW +: DW] = act_valid[i] ? DW'(acts[k][i]) : DW'($urandom);
      end
      wl_en  = inject && (t == 2);
      wl_row = IW'(1);
      for (int j = 0; j < N; j++) wl_data[j*DW +: DW] = 16'h0303;
      #1;
      if (inject && t == 2) chk(load_err == 1'b0, "R6", "flag before request", load_err, 0);
      if (inject && t == 3) chk(load_err == 1'b1, "R6", "flag after request", load_err, 1);
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          bit e = (t >= i + j) && (t < i + j + K);
          if (pe_active[i*N+j]) act_cnt++;
          if (pe_active[i*N+j] != e) abad++;
        end
      for (int j = 0; j < N; j++) begin
        int k = t - j - N;
        bit ev = (k >= 0 && k < K);
        if (ps_valid[j] != ev) vbad++;
        if (ev && ps_valid[j])
          chk(longint'($signed(ps_data[j*AW +: AW])) == exp_sum(k, j), tag, "column sum",
              longint'($signed(ps_data[j*AW +: AW])), exp_sum(k, j));
      end
    end
    @(negedge clk);
    wl_en = 1'b0;
    act_valid = '0;
    chk(abad == 0, "R3", "active window mismatches", abad, 0);
    chk(vbad == 0, "R8", "result valid mismatches", vbad, 0);
    chk(act_cnt == N*N*K, "R5", "total active element-cycles", act_cnt, N*N*K);
  endtask

  task automatic rand_weights();
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) w_m[i][j] = rnd16();
  endtask

  task automatic rand_acts(int K);
    for (int k = 0; k < K; k++) for (int i = 0; i < N; i++) acts[k][i] = rnd16();
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(ps_valid == '0, "R1", "ps_valid in reset", ps_valid, 0);
    chk(pe_active == '0, "R1", "pe_active in reset", pe_active, 0);
    chk(load_err == 1'b0, "R1", "load_err in reset", load_err, 0);
    rst = 1'b0;

    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) w_m[i][j] = 0;
    rand_acts(5);
    run_stream(5, 0, "R1");

    rand_weights();
    load_weights();
    rand_acts(64);
    run_stream(64, 0, "R2/R4");

    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) w_m[i][j] = -32768;
    for (int k = 0; k < 4; k++) for (int i = 0; i < N; i++) acts[k][i] = -32768;
    for (int i = 0; i < N; i++) acts[1][i] = 32767;
    load_weights();
    run_stream(4, 0, "R7");
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) w_m[i][j] = (j % 2) ? 32767 : -32768;
    load_weights();
    run_stream(4, 0, "R7");

    rand_weights();
    load_weights();
    rand_acts(10);
    run_stream(10, 1, "R6");
    chk(load_err == 1'b1, "R6", "flag sticky after run", load_err, 1);

    rand_weights();
    load_weights();
    chk(load_err == 1'b1, "R6", "flag sticky after idle load", load_err, 1);
    rand_acts(1);
    run_stream(1, 0, "R2");
    rand_acts(17);
    run_stream(17, 0, "R4");

    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(load_err == 1'b0, "R1", "flag cleared by reset", load_err, 0);
    rst = 1'b0;
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) w_m[i][j] = 0;
    rand_acts(3);
    run_stream(3, 0, "R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule